// File: doc/BRIEF.md
# Gated 32-bit Period Timer

This block is a 32-bit up-counter, held as a low and a high 16-bit half, that advances on an internal instruction-rate tick after a selectable prescaler. In period mode it counts from its current value up to a 32-bit period value and then wraps to zero. In gated accumulation mode it counts only while an external gate input is high, so the count measures how long the gate was high. It never wraps to zero at the period value in this mode.

Reaching the period value produces a one-cycle trigger pulse for an ADC. The same event, or in gated mode the gate falling, sets a sticky interrupt flag. Software clears the flag and can mask it onto an interrupt output. A plain write port loads the counter halves, the period halves and a control register, and clears the flag. A sleep input freezes all counting.

Register addresses on `wrAddr`: 0 counter low half, 1 counter high half, 2 period low half, 3 period high half, 4 control, 5 flag clear (takes effect when data bit 0 is 1). Control bits: bit 0 enable, bit 1 external clock select (when 1, the counter does not advance), bit 2 gated mode, bits 4:3 prescale select, bit 5 interrupt enable.

Top module: `gate_timer32`

## Requirements
- R1: With control bits 4:3 set to 00, 01, 10 or 11, the count rises by one for every 1, 8, 64 or 256 cycles with `tickEn` high, counted from the last prescaler clear.
- R2: In period mode, the count steps by one up to the period value. On the next increment it returns to zero.
- R3: `adcTrig` is high for exactly one clock: the first cycle in which `countOut` equals the period value after an increment.
- R4: `intFlag` is set by a period match and stays set until a write to address 5 with data bit 0 at 1. `intOut` is `intFlag` AND control bit 5.
- R5: In gated mode (control bits 0 and 2 at 1, bit 1 at 0), the count advances only while the gate is high. The gate passes through a two-flop synchroniser, so the count lags the gate by two clocks.
- R6: In gated mode, a falling gate edge sets `intFlag` and leaves the count intact. A later gate pulse adds to that count.
- R7: In gated mode, the count runs past the period value without wrapping, and the match still sets `intFlag`.
- R8: A write to either counter half or to the control register clears the prescaler while the timer is enabled. A control write leaves the count unchanged.
- R9: While disabled, the count holds, but writes still load the counter halves.
- R10: While `sleep` is high, neither the count nor the prescaler advances. The partial prescale count is kept.
- R11: A counter-half write in the same cycle as an increment loads the written value, with no increment applied.
- R12: With control bit 1 at 1 the count does not advance. With gated mode off, a falling gate edge does not set `intFlag`.
- R13: After reset, `countOut`, `adcTrig`, `intFlag` and `intOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Instruction-rate tick enable |
| sleep | input | 1 | Freezes counting while high |
| gateIn | input | 1 | Asynchronous gate input |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| countOut | output | 32 | Current 32-bit count |
| adcTrig | output | 1 | One-cycle period-match pulse |
| intFlag | output | 1 | Sticky interrupt flag |
| intOut | output | 1 | Masked interrupt request |

## Verification
A prescaler state that is wrong in the wrong place shows as a count that is early or late by a fixed number of cycles. It becomes visible at `countOut` within one prescale period after a clear or a resume from sleep. A corrupted synchroniser or edge register shows as a gated total that differs from the number of high cycles, or as a flag that fails to set. Either appears three clocks after the gate falls. Match logic errors show the same cycle the count reaches the period: a missing or doubled `adcTrig`, or a count that fails to wrap.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] ADDR_CNT_LO = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CNT_HI = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_PER_LO = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PER_HI = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_CLR    = 3'd5;
  localparam int CTL_W = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic ldLo;
    logic ldHi;
    logic ldPerLo;
    logic ldPerHi;
    logic step;
    logic wrapOn;
  } dpStrobe_t;
endpackage

// File: rtl/gtmr_datapath.sv
module gtmr_datapath
  import gtmr_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [HALF_W-1:0]     wrData,
  output logic [2*HALF_W-1:0]   count,
  output logic                  hitNow
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] perQ;
  logic [CNT_W-1:0] nextVal;

  always_comb begin
    if (strobe.wrapOn && (cntQ == perQ)) nextVal = '0;
    else                                 nextVal = cntQ + CNT_W'(1);
  end

  // a match is an increment that lands on the period value
  assign hitNow = strobe.step && (nextVal == perQ) && (nextVal != cntQ);
  assign count  = cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.ldLo || strobe.ldHi) begin
      if (strobe.ldLo) cntQ[HALF_W-1:0]     <= wrData;
      if (strobe.ldHi) cntQ[CNT_W-1:HALF_W] <= wrData;
    end else if (strobe.step) begin
      cntQ <= nextVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perQ <= '1;
    end else begin
      if (strobe.ldPerLo) perQ[HALF_W-1:0]     <= wrData;
      if (strobe.ldPerHi) perQ[CNT_W-1:HALF_W] <= wrData;
    end
  end
endmodule

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  sleep,
  input  logic                  gateIn,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [CTL_W-1:0]      ctlData,
  input  logic                  hitNow,
  output dpStrobe_t             strobe,
  output logic                  adcTrig,
  output logic                  intFlag,
  output logic                  intOut
);
  logic             ctlEn, ctlExt, ctlGate, ctlIe;
  logic [1:0]       ctlSel;
  logic             gS1, gS2, gPrev;
  logic [PSC_W-1:0] pscCnt;
  logic [PSC_W-1:0] pscLim;
  logic             trigQ, flagQ;
  logic             gatedMode, run, wrCtl, wrCnt, pscClr, pscDone, gateFall, flagClr;

  always_comb begin
    case (ctlSel)
      2'd0:    pscLim = PSC_W'(0);
      2'd1:    pscLim = PSC_W'(7);
      2'd2:    pscLim = PSC_W'(63);
      default: pscLim = PSC_W'(255);
    endcase
  end

  assign gatedMode = ctlEn & ~ctlExt & ctlGate;
  assign run       = ctlEn & ~ctlExt & ~sleep & tickEn & (~gatedMode | gS2);
  assign wrCtl     = wrEn & (wrAddr == ADDR_CTRL);
  assign wrCnt     = wrEn & ((wrAddr == ADDR_CNT_LO) | (wrAddr == ADDR_CNT_HI));
  assign pscClr    = ctlEn & (wrCtl | wrCnt);
  assign pscDone   = run & (pscCnt >= pscLim);
  assign gateFall  = gatedMode & gPrev & ~gS2;
  assign flagClr   = wrEn & (wrAddr == ADDR_CLR) & ctlData[0];

  always_comb begin
    strobe.ldLo    = wrEn & (wrAddr == ADDR_CNT_LO);
    strobe.ldHi    = wrEn & (wrAddr == ADDR_CNT_HI);
    strobe.ldPerLo = wrEn & (wrAddr == ADDR_PER_LO);
    strobe.ldPerHi = wrEn & (wrAddr == ADDR_PER_HI);
    strobe.step    = pscDone & ~pscClr & ~wrCnt;
    strobe.wrapOn  = ~gatedMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlEn   <= 1'b0;
      ctlExt  <= 1'b0;
      ctlGate <= 1'b0;
      ctlSel  <= 2'd0;
      ctlIe   <= 1'b0;
    end else if (wrCtl) begin
      ctlEn   <= ctlData[0];
      ctlExt  <= ctlData[1];
      ctlGate <= ctlData[2];
      ctlSel  <= ctlData[4:3];
      ctlIe   <= ctlData[5];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gS1   <= 1'b0;
      gS2   <= 1'b0;
      gPrev <= 1'b0;
    end else begin
      gS1   <= gateIn;
      gS2   <= gS1;
      gPrev <= gS2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pscCnt <= '0;
    else if (pscClr)  pscCnt <= '0;
    else if (pscDone) pscCnt <= '0;
    else if (run)     pscCnt <= pscCnt + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      trigQ <= hitNow;
      flagQ <= (flagQ & ~flagClr) | hitNow | gateFall;
    end
  end

  assign adcTrig = trigQ;
  assign intFlag = flagQ;
  assign intOut  = flagQ & ctlIe;
endmodule

// File: rtl/gate_timer32.sv
module gate_timer32
  import gtmr_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PSC_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  sleep,
  input  logic                  gateIn,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [HALF_W-1:0]     wrData,
  output logic [2*HALF_W-1:0]   countOut,
  output logic                  adcTrig,
  output logic                  intFlag,
  output logic                  intOut
);
  dpStrobe_t strobe;
  logic      hitNow;

  gtmr_ctrl #(.PSC_W(PSC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sleep(sleep), .gateIn(gateIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .ctlData(wrData[CTL_W-1:0]), .hitNow(hitNow),
    .strobe(strobe), .adcTrig(adcTrig), .intFlag(intFlag), .intOut(intOut)
  );

  gtmr_datapath #(.HALF_W(HALF_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .count(countOut), .hitNow(hitNow)
  );
endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker
  import gtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sleep,
  input logic                  wrEn,
  input logic [REG_ADDR_W-1:0] wrAddr,
  input logic                  clrBit,
  input logic [CNT_W-1:0]      countOut,
  input logic                  adcTrig,
  input logic                  intFlag,
  input logic                  intOut
);
  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    adcTrig |=> !adcTrig); // R3

  AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    adcTrig |-> intFlag); // R4

  AST_INT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> intFlag); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(intFlag) && !($past(wrEn) && $past(wrAddr) == ADDR_CLR && $past(clrBit)))
      |-> intFlag); // R4

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sleep) && !$past(wrEn)) |-> (countOut == $past(countOut))); // R10

  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((countOut != $past(countOut)) && !$past(wrEn))
      |-> ((countOut == $past(countOut) + CNT_W'(1)) || (countOut == '0))); // R2
endmodule

bind gate_timer32 gtmr_checker #(.CNT_W(2*HALF_W)) uChk (
  .clk(clk), .rstN(rstN), .sleep(sleep), .wrEn(wrEn), .wrAddr(wrAddr),
  .clrBit(wrData[0]), .countOut(countOut), .adcTrig(adcTrig),
  .intFlag(intFlag), .intOut(intOut)
);

// File: tb/gate_timer32_test.sv
module gate_timer32_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        sleep = 1'b0;
  logic        gateIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [31:0] countOut;
  logic        adcTrig, intFlag, intOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int NV = 5;
  localparam int V_SEL [NV] = '{0, 1, 2, 3, 1};
  localparam int V_CYC [NV] = '{10, 20, 130, 600, 15};
  localparam int V_EXP [NV] = '{10, 2, 2, 2, 1};

  always #2.5 clk = ~clk;

  gate_timer32 uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sleep(sleep), .gateIn(gateIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .countOut(countOut),
    .adcTrig(adcTrig), .intFlag(intFlag), .intOut(intOut)
  );

  function automatic logic [15:0] ctl(input bit en, input bit ext, input bit gate,
                                      input int sel, input bit ie);
    return {10'd0, ie, 2'(sel), gate, ext, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] per, input logic [15:0] ctrlVal);
    wr(3'd4, 16'h0000);
    wr(3'd3, per[31:16]);
    wr(3'd2, per[15:0]);
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h0001);
    wr(3'd4, ctrlVal);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    run(3);
    chk("R13 count", countOut, 0);
    chk("R13 trig", {31'd0, adcTrig}, 0);
    chk("R13 flag", {31'd0, intFlag}, 0);
    chk("R13 int", {31'd0, intOut}, 0);
    rstN = 1'b1;
    tickEn = 1'b1;
    run(2);

    // R1 prescale vectors
    for (int i = 0; i < NV; i++) begin
      wr(3'd4, ctl(1, 0, 0, V_SEL[i], 0));
      wr(3'd1, 16'h0000);
      wr(3'd0, 16'h0000);
      run(V_CYC[i]);
      chk($sformatf("R1 vector %0d", i), countOut, V_EXP[i]);
    end

    // R8 control write keeps count
    wr(3'd4, ctl(1, 0, 0, 1, 0));
    chk("R8 ctrl write keeps count", countOut, 1);

    // R8 prescaler clear by control write
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0000);
    run(5);
    wr(3'd4, ctl(1, 0, 0, 1, 0));
    run(7);
    chk("R8 no step before 8 after clear", countOut, 0);
    run(1);
    chk("R8 step 8 after clear", countOut, 1);

    // R11 write beats increment
    wr(3'd4, ctl(1, 0, 0, 0, 0));
    wr(3'd0, 16'd100);
    chk("R11 loaded value", countOut, 100);
    run(1);
    chk("R11 next increment", countOut, 101);

    // R9 disabled holds, writes load
    wr(3'd4, ctl(0, 0, 0, 0, 0));
    begin
      logic [31:0] held;
      held = countOut;
      run(20);
      chk("R9 hold while disabled", countOut, held);
    end
    wr(3'd0, 16'd7);
    chk("R9 write while disabled", countOut, 7);
    run(5);
    chk("R9 still held", countOut, 7);

    // R12 external select stops counting
    wr(3'd4, ctl(1, 1, 0, 0, 0));
    run(10);
    chk("R12 external select frozen", countOut, 7);

    // R10 sleep keeps prescaler partial count
    wr(3'd4, ctl(1, 0, 0, 1, 0));
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0000);
    run(5);
    sleep = 1'b1;
    run(10);
    chk("R10 frozen in sleep", countOut, 0);
    sleep = 1'b0;
    run(2);
    chk("R10 partial kept", countOut, 0);
    run(1);
    chk("R10 resume step", countOut, 1);

    // R2 R3 R4 period mode
    setup(32'd5, ctl(1, 0, 0, 0, 0));
    for (int k = 1; k <= 13; k++) begin
      run(1);
      chk($sformatf("R2 count k=%0d", k), countOut, k % 6);
      chk($sformatf("R3 trig k=%0d", k), {31'd0, adcTrig}, (k % 6 == 5) ? 1 : 0);
      chk($sformatf("R4 flag k=%0d", k), {31'd0, intFlag}, (k >= 5) ? 1 : 0);
    end
    chk("R4 masked", {31'd0, intOut}, 0);
    wr(3'd4, ctl(1, 0, 0, 0, 1));
    chk("R4 int enabled", {31'd0, intOut}, 1);
    wr(3'd4, ctl(0, 0, 0, 0, 1));
    wr(3'd5, 16'h0001);
    chk("R4 flag cleared", {31'd0, intFlag}, 0);
    chk("R4 int cleared", {31'd0, intOut}, 0);
    run(3);
    chk("R4 flag stays clear", {31'd0, intFlag}, 0);

    // R5 R6 gated accumulation
    setup(32'hFFFF_FFFF, ctl(1, 0, 1, 0, 0));
    run(5);
    chk("R5 gate low no count", countOut, 0);
    gateIn = 1'b1;
    run(12);
    chk("R5 count lags gate", countOut, 10);
    chk("R6 no flag while high", {31'd0, intFlag}, 0);
    gateIn = 1'b0;
    run(5);
    chk("R5 gated total", countOut, 12);
    chk("R6 fall sets flag", {31'd0, intFlag}, 1);
    wr(3'd5, 16'h0001);
    gateIn = 1'b1;
    run(7);
    gateIn = 1'b0;
    run(5);
    chk("R6 accumulates", countOut, 19);
    chk("R6 second fall flag", {31'd0, intFlag}, 1);

    // R7 gated mode passes period
    setup(32'd3, ctl(1, 0, 1, 0, 0));
    gateIn = 1'b1;
    run(8);
    chk("R7 no wrap", countOut, 6);
    chk("R7 match flag", {31'd0, intFlag}, 1);
    gateIn = 1'b0;
    run(5);

    // R12 gate fall ignored outside gated mode
    setup(32'hFFFF_FFFF, ctl(1, 0, 0, 0, 0));
    gateIn = 1'b1;
    run(4);
    gateIn = 1'b0;
    run(6);
    chk("R12 no flag from gate", {31'd0, intFlag}, 0);
    chk("R12 free count", countOut, 10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule